// File: doc/BRIEF.md
# Privileged Pending-Interrupt Identifier Read Arbiter

This block settles what happens when software reads the register that reports the most urgent pending group-0 interrupt identifier. The read can come from any of four privilege levels, 0 to 3. The block weighs that level against several inputs: whether levels 2 and 3 are present and enabled, and which register width (wide or narrow) each of them uses. It also weighs the trap and redirect controls that each width provides, the per-level register-interface enables, and two debug-related undefined conditions. It then gives exactly one outcome:

- undefined instruction;
- trap to level 2 with a syndrome code;
- trap to level 3;
- read of the virtual identifier;
- read of the physical identifier.

Requests arrive on a valid/ready handshake. Each accepted request produces one registered response, which stays on the outputs until the consumer takes it. When the outcome is a read, the returned word carries the identifier in its low bits, masked to the identifier width in use (16 or 24 bits). The special "nothing observable" identifiers pass through unchanged. The block does not work out which interrupt is pending; it only gates and routes the read of that value.

Top module: `pend_id_access_arb`

## Requirements
- R1: A request whose `req_level` is 0 always yields the undefined outcome, whatever the other inputs are.
- R2: At level 1 the checks run in this order, and the first one that matches decides the outcome:
  - undefined when the early debug condition and effective level-3 fast-interrupt routing both hold;
  - trap to level 2 on the coprocessor-access trap;
  - undefined when `if_en_l1` is 0;
  - trap to level 2 on the group-0 trap-all control;
  - virtual read on the fast-interrupt virtualisation control;
  - the level-3 routing check;
  - otherwise a physical read.
- R3: Every trap to level 2 reports `rsp_syndrome` = 6'h03. Every other outcome reports 6'h00.
- R4: Effective level-3 fast-interrupt routing requires `l3_present` = 1. When it holds at the routing step, the outcome is undefined if `dbg_undef` = 1 and trap to level 3 otherwise.
- R5: When level 3 uses the narrow width (`l3_wide` = 0) and `in_monitor` = 1, both level-3 routing checks at level 1 are skipped. With the wide width, `in_monitor` has no effect.
- R6: At level 2 the checks run in this order: the early-undefined routing check, then undefined when `if_en_l2` is 0, then the routing step of R4, then a physical read. The level-2 controls and `in_monitor` have no effect at level 2.
- R7: At level 3 the outcome is undefined when `if_en_l3` is 0 and a physical read otherwise. All other controls are ignored.
- R8: On a read, `rsp_data[23:0]` carries the selected identifier and `rsp_data[31:24]` is 0. When `id_wide` = 0, `rsp_data[23:16]` is also 0. The mask applies to both the physical and the virtual source.
- R9: The identifier values 1020, 1021 and 1023 are returned unchanged from either source, at either width.
- R10: While `rsp_valid` = 1, exactly one of the five outcome outputs is 1. While `rsp_valid` = 0, all five outcome outputs are 0. `rsp_data` is 0 for any outcome other than a read.
- R11: `req_ready` = 1 exactly when `rsp_valid` = 0 or `rsp_ready` = 1. A request accepted on a clock edge appears on the response outputs right after that edge. The response is held unchanged while `rsp_ready` = 0.
- R12: Asserting `rst_n` low clears `rsp_valid`, all outcome outputs, the syndrome and the data at once.
- R13: Level 2's three controls are taken from the wide copy when `l2_wide` = 1 and from the narrow copy otherwise, and only when `l2_enabled` = 1. The level-3 routing bit is likewise taken from the copy that `l3_wide` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted |
| req_level | input | 2 | Privilege level of the read (0 to 3) |
| in_monitor | input | 1 | Processor is in the narrow-width secure monitor mode |
| l2_enabled | input | 1 | Level 2 present and enabled |
| l2_wide | input | 1 | Level 2 uses the wide register width |
| l2_cp_trap_wide | input | 1 | Coprocessor-access trap, wide copy |
| l2_cp_trap_narrow | input | 1 | Coprocessor-access trap, narrow copy |
| l2_grp0_trap_wide | input | 1 | Group-0 trap-all, wide copy |
| l2_grp0_trap_narrow | input | 1 | Group-0 trap-all, narrow copy |
| l2_fiq_virt_wide | input | 1 | Fast-interrupt virtualisation, wide copy |
| l2_fiq_virt_narrow | input | 1 | Fast-interrupt virtualisation, narrow copy |
| l3_present | input | 1 | Level 3 implemented |
| l3_wide | input | 1 | Level 3 uses the wide register width |
| l3_fiq_route_wide | input | 1 | Fast-interrupt routing to level 3, wide copy |
| l3_fiq_route_narrow | input | 1 | Fast-interrupt routing to level 3, narrow copy |
| dbg_undef_early | input | 1 | Debug condition that makes routing undefined at the head of the chain |
| dbg_undef | input | 1 | Debug condition that turns a level-3 trap into undefined |
| if_en_l1 | input | 1 | Register-interface enable for level 1 |
| if_en_l2 | input | 1 | Register-interface enable for level 2 |
| if_en_l3 | input | 1 | Register-interface enable for level 3 |
| id_wide | input | 1 | Static: 1 selects 24 identifier bits, 0 selects 16 |
| phys_id | input | 24 | Physical pending identifier |
| virt_id | input | 24 | Virtual pending identifier |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_undef | output | 1 | Outcome: undefined instruction |
| rsp_trap_l2 | output | 1 | Outcome: trap to level 2 |
| rsp_trap_l3 | output | 1 | Outcome: trap to level 3 |
| rsp_virt | output | 1 | Outcome: virtual identifier read |
| rsp_phys | output | 1 | Outcome: physical identifier read |
| rsp_syndrome | output | 6 | Syndrome code of a level-2 trap |
| rsp_data | output | 32 | Read data |

## Verification
A fault in the priority chain shows as a wrong outcome flag on the response that follows the request's acceptance edge. The vectors are built so that each input combination matches two checks at once, and only the correct order picks the expected flag. The unselected copy of every width-dependent control is driven to the opposite value, so taking a control from the wrong source changes the outcome on that same response. A fault in the response register shows within one or two cycles: two flags at once, flags that remain after the response is consumed, data that changes during a stall, or a request accepted while the response is held.

// File: rtl/pend_id_access_pkg.sv
package pend_id_access_pkg;

  localparam int SYND_W = 6;
  localparam logic [SYND_W-1:0] SYND_TRAP_L2 = 6'h03;
  localparam int NUM_RES = 5;

  // Outcome codes; the code is also the bit index into the one-hot flag vector.
  typedef enum logic [2:0] {
    RES_UNDEF   = 3'd0,
    RES_TRAP_L2 = 3'd1,
    RES_TRAP_L3 = 3'd2,
    RES_VIRT    = 3'd3,
    RES_PHYS    = 3'd4
  } res_code_e;

  // Effective controls after width selection.
  typedef struct packed {
    logic cp_trap;
    logic grp0_trap;
    logic fiq_virt;
    logic route_at_l1;
    logic route_at_l2;
  } eff_ctl_t;

endpackage

// File: rtl/pend_id_ctl_select.sv
module pend_id_ctl_select
  import pend_id_access_pkg::*;
#(
  parameter int NUM_L2_CTL = 3
) (
  input  logic                  l2_enabled,
  input  logic                  l2_wide,
  input  logic [NUM_L2_CTL-1:0] l2_ctl_wide,
  input  logic [NUM_L2_CTL-1:0] l2_ctl_narrow,
  input  logic                  l3_present,
  input  logic                  l3_wide,
  input  logic                  route_wide,
  input  logic                  route_narrow,
  input  logic                  in_monitor,
  output eff_ctl_t              eff
);

  logic [NUM_L2_CTL-1:0] l2_sel;

  // One selector per level-2 control: width copy chosen, gated by enable. R13
  for (genvar g = 0; g < NUM_L2_CTL; g++) begin : g_l2_sel
    assign l2_sel[g] = l2_enabled & (l2_wide ? l2_ctl_wide[g] : l2_ctl_narrow[g]);
  end

  logic route_raw;
  logic monitor_skip;

  always_comb begin
    route_raw    = l3_present & (l3_wide ? route_wide : route_narrow);
    // Narrow level 3 in monitor mode suppresses routing checks from level 1. R5
    monitor_skip = ~l3_wide & in_monitor;
    eff.cp_trap     = l2_sel[0];
    eff.grp0_trap   = l2_sel[1];
    eff.fiq_virt    = l2_sel[2];
    eff.route_at_l1 = route_raw & ~monitor_skip;
    eff.route_at_l2 = route_raw;
  end

endmodule

// File: rtl/pend_id_decide.sv
module pend_id_decide
  import pend_id_access_pkg::*;
(
  input  logic [1:0] level,
  input  eff_ctl_t   eff,
  input  logic       dbg_undef_early,
  input  logic       dbg_undef,
  input  logic       if_en_l1,
  input  logic       if_en_l2,
  input  logic       if_en_l3,
  output res_code_e  code
);

  res_code_e route_result;

  always_comb begin
    route_result = dbg_undef ? RES_UNDEF : RES_TRAP_L3;  // R4
    code = RES_UNDEF;
    unique case (level)
      2'd0: code = RES_UNDEF;  // R1
      2'd1: begin               // R2
        if (dbg_undef_early && eff.route_at_l1) code = RES_UNDEF;
        else if (eff.cp_trap)                   code = RES_TRAP_L2;
        else if (!if_en_l1)                     code = RES_UNDEF;
        else if (eff.grp0_trap)                 code = RES_TRAP_L2;
        else if (eff.fiq_virt)                  code = RES_VIRT;
        else if (eff.route_at_l1)               code = route_result;
        else                                    code = RES_PHYS;
      end
      2'd2: begin               // R6
        if (dbg_undef_early && eff.route_at_l2) code = RES_UNDEF;
        else if (!if_en_l2)                     code = RES_UNDEF;
        else if (eff.route_at_l2)               code = route_result;
        else                                    code = RES_PHYS;
      end
      default: code = if_en_l3 ? RES_PHYS : RES_UNDEF;  // R7
    endcase
  end

endmodule

// File: rtl/pend_id_mask.sv
module pend_id_mask #(
  parameter int ID_W        = 24,
  parameter int NARROW_ID_W = 16,
  parameter int DATA_W      = 32
) (
  input  logic              id_wide,
  input  logic [ID_W-1:0]   id_in,
  output logic [DATA_W-1:0] data_out
);

  // Per-bit keep logic: low bits always, upper id bits only in wide mode. R8
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < NARROW_ID_W) begin : g_low
      assign data_out[b] = id_in[b];
    end else if (b < ID_W) begin : g_mid
      assign data_out[b] = id_in[b] & id_wide;
    end else begin : g_top
      assign data_out[b] = 1'b0;
    end
  end

endmodule

// File: rtl/pend_id_resp_reg.sv
module pend_id_resp_reg
  import pend_id_access_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [NUM_RES-1:0] flags_in,
  input  logic [SYND_W-1:0]  synd_in,
  input  logic [DATA_W-1:0]  data_in,
  input  logic               rsp_ready,
  output logic               rsp_valid,
  output logic [NUM_RES-1:0] flags_out,
  output logic [SYND_W-1:0]  synd_out,
  output logic [DATA_W-1:0]  data_out
);

  logic               accept;
  logic               consume;
  logic               valid_q, valid_d;
  logic               load_en;
  logic [NUM_RES-1:0] flags_q, flags_d;
  logic [SYND_W-1:0]  synd_q, synd_d;
  logic [DATA_W-1:0]  data_q, data_d;

  always_comb begin
    req_ready = ~valid_q | rsp_ready;
    accept    = req_valid & req_ready;
    consume   = valid_q & rsp_ready;
    valid_d   = accept | (valid_q & ~rsp_ready);
    load_en   = accept | consume;
    if (accept) begin
      flags_d = flags_in;
      synd_d  = synd_in;
      data_d  = data_in;
    end else begin
      flags_d = '0;
      synd_d  = '0;
      data_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      synd_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        flags_q <= flags_d;
        synd_q  <= synd_d;
        data_q  <= data_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign flags_out = flags_q;
  assign synd_out  = synd_q;
  assign data_out  = data_q;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $onehot(flags_q)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (flags_q == '0)); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rsp_ready) |=> (valid_q && $stable(flags_q) && $stable(data_q) && $stable(synd_q))); // R11
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> valid_q); // R11
  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rsp_ready) |-> !req_ready); // R11

endmodule

// File: rtl/pend_id_access_arb.sv
module pend_id_access_arb
  import pend_id_access_pkg::*;
#(
  parameter int ID_W        = 24,
  parameter int NARROW_ID_W = 16,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_level,
  input  logic              in_monitor,
  input  logic              l2_enabled,
  input  logic              l2_wide,
  input  logic              l2_cp_trap_wide,
  input  logic              l2_cp_trap_narrow,
  input  logic              l2_grp0_trap_wide,
  input  logic              l2_grp0_trap_narrow,
  input  logic              l2_fiq_virt_wide,
  input  logic              l2_fiq_virt_narrow,
  input  logic              l3_present,
  input  logic              l3_wide,
  input  logic              l3_fiq_route_wide,
  input  logic              l3_fiq_route_narrow,
  input  logic              dbg_undef_early,
  input  logic              dbg_undef,
  input  logic              if_en_l1,
  input  logic              if_en_l2,
  input  logic              if_en_l3,
  input  logic              id_wide,
  input  logic [ID_W-1:0]   phys_id,
  input  logic [ID_W-1:0]   virt_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_undef,
  output logic              rsp_trap_l2,
  output logic              rsp_trap_l3,
  output logic              rsp_virt,
  output logic              rsp_phys,
  output logic [SYND_W-1:0] rsp_syndrome,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int NUM_L2_CTL = 3;

  eff_ctl_t           eff;
  res_code_e          code;
  logic [ID_W-1:0]    src_id;
  logic [DATA_W-1:0]  masked;
  logic [DATA_W-1:0]  data_next;
  logic [SYND_W-1:0]  synd_next;
  logic [NUM_RES-1:0] flags_next;
  logic [NUM_RES-1:0] flags_q;
  logic               is_read;

  pend_id_ctl_select #(.NUM_L2_CTL(NUM_L2_CTL)) u_sel (
    .l2_enabled    (l2_enabled),
    .l2_wide       (l2_wide),
    .l2_ctl_wide   ({l2_fiq_virt_wide, l2_grp0_trap_wide, l2_cp_trap_wide}),
    .l2_ctl_narrow ({l2_fiq_virt_narrow, l2_grp0_trap_narrow, l2_cp_trap_narrow}),
    .l3_present    (l3_present),
    .l3_wide       (l3_wide),
    .route_wide    (l3_fiq_route_wide),
    .route_narrow  (l3_fiq_route_narrow),
    .in_monitor    (in_monitor),
    .eff           (eff)
  );

  pend_id_decide u_dec (
    .level           (req_level),
    .eff             (eff),
    .dbg_undef_early (dbg_undef_early),
    .dbg_undef       (dbg_undef),
    .if_en_l1        (if_en_l1),
    .if_en_l2        (if_en_l2),
    .if_en_l3        (if_en_l3),
    .code            (code)
  );

  always_comb begin
    is_read    = (code == RES_VIRT) || (code == RES_PHYS);
    src_id     = (code == RES_VIRT) ? virt_id : phys_id;
    flags_next = NUM_RES'(1) << code;
    synd_next  = (code == RES_TRAP_L2) ? SYND_TRAP_L2 : '0;  // R3
  end

  pend_id_mask #(.ID_W(ID_W), .NARROW_ID_W(NARROW_ID_W), .DATA_W(DATA_W)) u_mask (
    .id_wide  (id_wide),
    .id_in    (src_id),
    .data_out (masked)
  );

  assign data_next = is_read ? masked : '0;  // R10

  pend_id_resp_reg #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .flags_in  (flags_next),
    .synd_in   (synd_next),
    .data_in   (data_next),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .flags_out (flags_q),
    .synd_out  (rsp_syndrome),
    .data_out  (rsp_data)
  );

  assign rsp_undef   = flags_q[RES_UNDEF];
  assign rsp_trap_l2 = flags_q[RES_TRAP_L2];
  assign rsp_trap_l3 = flags_q[RES_TRAP_L3];
  assign rsp_virt    = flags_q[RES_VIRT];
  assign rsp_phys    = flags_q[RES_PHYS];

  AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_level == 2'd0) |=> rsp_undef); // R1
  AST_LVL3_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_level == 2'd3) |=> (rsp_phys == $past(if_en_l3))); // R7
  AST_SYND_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap_l2) |-> (rsp_syndrome == 6'h03)); // R3
  AST_SYND_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_trap_l2) |-> (rsp_syndrome == '0)); // R3
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:ID_W] == '0)); // R8
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !id_wide) |-> (rsp_data[ID_W-1:NARROW_ID_W] == '0)); // R8
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_virt && !rsp_phys) |-> (rsp_data == '0)); // R10

endmodule

// File: tb/pend_id_access_arb_tb_top.sv
module pend_id_access_arb_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_level;
  logic        in_monitor, l2_enabled, l2_wide;
  logic        cp_w, cp_n, g0_w, g0_n, fv_w, fv_n;
  logic        l3_present, l3_wide, rt_w, rt_n;
  logic        dbg_early, dbg_late, en1, en2, en3, id_wide;
  logic [23:0] phys_id, virt_id;
  logic        rsp_valid, rsp_ready;
  logic        r_undef, r_t2, r_t3, r_virt, r_phys;
  logic [5:0]  rsp_syndrome;
  logic [31:0] rsp_data;

  pend_id_access_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .in_monitor(in_monitor), .l2_enabled(l2_enabled),
    .l2_wide(l2_wide), .l2_cp_trap_wide(cp_w), .l2_cp_trap_narrow(cp_n),
    .l2_grp0_trap_wide(g0_w), .l2_grp0_trap_narrow(g0_n),
    .l2_fiq_virt_wide(fv_w), .l2_fiq_virt_narrow(fv_n),
    .l3_present(l3_present), .l3_wide(l3_wide),
    .l3_fiq_route_wide(rt_w), .l3_fiq_route_narrow(rt_n),
    .dbg_undef_early(dbg_early), .dbg_undef(dbg_late),
    .if_en_l1(en1), .if_en_l2(en2), .if_en_l3(en3), .id_wide(id_wide),
    .phys_id(phys_id), .virt_id(virt_id), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_undef(r_undef), .rsp_trap_l2(r_t2),
    .rsp_trap_l3(r_t3), .rsp_virt(r_virt), .rsp_phys(r_phys),
    .rsp_syndrome(rsp_syndrome), .rsp_data(rsp_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Outcome codes: 0 undef, 1 trap l2, 2 trap l3, 3 virt read, 4 phys read.
  // Vector: {req[3:0], level[1:0], mon, l2en l2w, cp g0 fv, l3p l3w rt, early late, en1 en2 en3, exp[2:0]}
  localparam int NV = 23;
  localparam logic [22:0] VECS [NV] = '{
    {4'd1,  2'd0, 14'b0_11_000_110_00_111, 3'd0},  // R1 level 0, all enabled
    {4'd1,  2'd0, 14'b0_00_000_000_00_000, 3'd0},  // R1 level 0, all clear
    {4'd2,  2'd1, 14'b0_11_000_110_00_111, 3'd4},  // R2 plain physical read
    {4'd4,  2'd1, 14'b0_11_100_111_10_111, 3'd0},  // R4 early undef beats cp trap
    {4'd2,  2'd1, 14'b0_11_100_110_00_011, 3'd1},  // R2 cp trap beats en1 clear
    {4'd13, 2'd1, 14'b0_10_100_110_00_011, 3'd1},  // R13 cp trap narrow copy
    {4'd2,  2'd1, 14'b0_11_010_110_00_011, 3'd0},  // R2 en1 clear beats grp0 trap
    {4'd3,  2'd1, 14'b0_11_011_110_00_111, 3'd1},  // R3 grp0 trap beats virt
    {4'd2,  2'd1, 14'b0_11_001_111_00_111, 3'd3},  // R2 virt beats routing
    {4'd4,  2'd1, 14'b0_01_001_111_00_111, 3'd2},  // R4 l2 disabled -> trap l3
    {4'd4,  2'd1, 14'b0_11_000_111_01_111, 3'd0},  // R4 late debug -> undef
    {4'd4,  2'd1, 14'b0_11_000_011_11_111, 3'd4},  // R4 no level 3 -> phys
    {4'd5,  2'd1, 14'b1_11_000_101_11_111, 3'd4},  // R5 narrow l3 monitor skip
    {4'd5,  2'd1, 14'b0_11_000_101_00_111, 3'd2},  // R5 narrow l3 not monitor
    {4'd5,  2'd1, 14'b1_11_000_111_00_111, 3'd2},  // R5 wide l3 monitor ignored
    {4'd6,  2'd2, 14'b0_11_111_110_00_010, 3'd4},  // R6 l2 controls ignored
    {4'd6,  2'd2, 14'b0_11_000_111_10_101, 3'd0},  // R6 early undef
    {4'd6,  2'd2, 14'b0_11_000_111_00_101, 3'd0},  // R6 en2 clear beats routing
    {4'd6,  2'd2, 14'b1_11_000_101_00_111, 3'd2},  // R6 monitor ignored at l2
    {4'd4,  2'd2, 14'b0_11_000_111_01_111, 3'd0},  // R4 late debug at l2
    {4'd7,  2'd3, 14'b0_11_000_110_00_110, 3'd0},  // R7 en3 clear
    {4'd7,  2'd3, 14'b0_11_111_111_11_111, 3'd4},  // R7 everything else ignored
    {4'd13, 2'd1, 14'b0_10_001_110_00_111, 3'd3}   // R13 virt narrow copy
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] flags();
    return {r_phys, r_virt, r_t3, r_t2, r_undef};
  endfunction

  // Drives the selected width copy and the opposite value on the other copy.
  task automatic set_ctrl(input logic [22:0] v);
    req_level  = v[18:17];
    in_monitor = v[16];
    l2_enabled = v[15];
    l2_wide    = v[14];
    cp_w = v[14] ? v[13] : ~v[13];  cp_n = v[14] ? ~v[13] : v[13];
    g0_w = v[14] ? v[12] : ~v[12];  g0_n = v[14] ? ~v[12] : v[12];
    fv_w = v[14] ? v[11] : ~v[11];  fv_n = v[14] ? ~v[11] : v[11];
    l3_present = v[10];
    l3_wide    = v[9];
    rt_w = v[9] ? v[8] : ~v[8];     rt_n = v[9] ? ~v[8] : v[8];
    dbg_early = v[7];
    dbg_late  = v[6];
    en1 = v[5];  en2 = v[4];  en3 = v[3];
  endtask

  task automatic issue_one();
    @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1; id_wide = 1'b1;
    phys_id = '0; virt_id = '0;
    set_ctrl(VECS[2]);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 1'b0, "R12", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk(flags() == 5'd0, "R12", "flags in reset", 32'(flags()), 32'd0);
    chk(req_ready == 1'b1, "R11", "ready when idle", 32'(req_ready), 32'd1);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      logic [4:0]  ef;
      logic [31:0] ed;
      string       tag;
      v = VECS[i];
      tag = $sformatf("R%0d", v[22:19]);
      @(negedge clk);
      set_ctrl(v);
      phys_id = 24'hA50000 + 24'(i);
      virt_id = 24'h5A1000 + 24'(i);
      issue_one();
      ef = 5'd1 << v[2:0];
      ed = (v[2:0] == 3'd4) ? {8'd0, phys_id} : (v[2:0] == 3'd3) ? {8'd0, virt_id} : 32'd0;
      chk(rsp_valid == 1'b1, tag, $sformatf("vec %0d valid", i), 32'(rsp_valid), 32'd1);
      chk(flags() == ef, tag, $sformatf("vec %0d outcome", i), 32'(flags()), 32'(ef));
      chk(rsp_data == ed, "R8", $sformatf("vec %0d data", i), rsp_data, ed);
      chk(rsp_syndrome == ((v[2:0] == 3'd1) ? 6'h03 : 6'h00), "R3",
          $sformatf("vec %0d syndrome", i), 32'(rsp_syndrome),
          (v[2:0] == 3'd1) ? 32'h3 : 32'h0);
    end

    // R8 narrow identifier width, physical then virtual
    @(negedge clk);
    id_wide = 1'b0;
    set_ctrl(VECS[2]);
    phys_id = 24'hABCDEF;
    issue_one();
    chk(rsp_data == 32'h0000CDEF, "R8", "narrow phys", rsp_data, 32'h0000CDEF);
    @(negedge clk);
    set_ctrl(VECS[8]);
    virt_id = 24'h7F1234;
    issue_one();
    chk(rsp_data == 32'h00001234, "R8", "narrow virt", rsp_data, 32'h00001234);

    // R9 special identifiers
    @(negedge clk);
    set_ctrl(VECS[2]);
    phys_id = 24'd1020;
    issue_one();
    chk(rsp_data == 32'd1020, "R9", "1020 narrow phys", rsp_data, 32'd1020);
    @(negedge clk);
    id_wide = 1'b1;
    set_ctrl(VECS[8]);
    virt_id = 24'd1021;
    issue_one();
    chk(rsp_data == 32'd1021, "R9", "1021 wide virt", rsp_data, 32'd1021);
    @(negedge clk);
    set_ctrl(VECS[2]);
    phys_id = 24'd1023;
    issue_one();
    chk(rsp_data == 32'd1023, "R9", "1023 wide phys", rsp_data, 32'd1023);

    // R11 stall and hold
    @(negedge clk);
    rsp_ready = 1'b0;
    phys_id = 24'h111111;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    phys_id = 24'h222222;  // second request kept pending
    chk(rsp_data == 32'h00111111, "R11", "first data", rsp_data, 32'h00111111);
    chk(req_ready == 1'b0, "R11", "ready low in stall", 32'(req_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_data == 32'h00111111, "R11", "held in stall", rsp_data, 32'h00111111);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_data == 32'h00222222, "R11", "second data", rsp_data, 32'h00222222);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "consumed", 32'(rsp_valid), 32'd0);
    chk(flags() == 5'd0, "R10", "flags idle", 32'(flags()), 32'd0);

    // R12 reset while a response is held
    rsp_ready = 1'b0;
    issue_one();
    chk(rsp_valid == 1'b1, "R12", "held before reset", 32'(rsp_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk(rsp_valid == 1'b0 && flags() == 5'd0 && rsp_data == 32'd0, "R12",
        "cleared by reset", {rsp_data[26:0], flags()}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rsp_ready = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule